// File: doc/BRIEF.md
# Clocked Synchronous Serial Transmitter

This block sends 8-bit frames over a data line paired with a serial clock. A host writes a byte into a holding register. When the transmitter is free, it copies that byte into a shift register and sends it starting with bit 0. Because there are two registers, the host can write the next byte while the current one is still going out. At the end of each frame the transmitter checks whether a new byte is waiting. If one is, the next frame follows with no idle time between them. If not, the transmitter stops, raises a transmit-end flag and holds the data line at the level of the last bit.

The serial clock has two sources. In internal mode the block makes it from the system clock with a programmable divider and drives it on its clock output. In external mode it follows an input clock, which is first passed through a synchronizer. Two flags report "holding register empty" and "transmission finished". Each flag has an enable that turns it into a level interrupt request. A receive-error input (three flag bits) blocks the start of any new frame while any of its bits is set.

Top module: `syncSerialTx`

## Requirements
- R1: Out of reset, emptyFlag=1, endFlag=1, txOut=1 and sckOut=1.
- R2: A host write (wrEn=1 at a clock edge) stores wrData and makes both emptyFlag and endFlag read 0 after that edge.
- R3: A frame is 8 bits, bit 0 first. In internal mode txOut changes only in the cycle where sckOut falls, so each bit is stable at the rising edge of sckOut.
- R4: In internal mode, when emptyFlag=0 and rxErr=0, the stored byte is moved to the shift register at the next edge. emptyFlag then reads 1, sckOut goes low and bit 0 appears on txOut.
- R5: txIrq is 1 exactly when txIntEn=1 and emptyFlag=1.
- R6: endIrq is 1 exactly when endIntEn=1 and endFlag=1.
- R7: If emptyFlag=0 at the edge that closes the last bit of a frame, the next frame starts at that edge. The serial clock period stays the same across the frame boundary, and endFlag stays 0.
- R8: If no new byte is waiting when the last bit closes, endFlag becomes 1 and txOut keeps the level of that last bit until the next frame loads.
- R9: In internal mode each half period of sckOut lasts clkDiv+1 system clocks (full period 2*(clkDiv+1)), and sckOut rests high once transmission has ended.
- R10: In external mode sckOut is held high, a frame loads only on a synchronized falling edge of sckIn, each later falling edge moves to the next bit, and falling edges of sckIn while nothing is pending have no effect.
- R11: While any rxErr bit is 1, no frame starts: emptyFlag stays 0 after a write and sckOut stays high. Once rxErr clears, the pending byte is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Host write strobe for the holding register |
| wrData | input | 8 | Byte to transmit |
| extClkMode | input | 1 | 1 selects the external serial clock, 0 the internal divider |
| clkDiv | input | 8 | Half period of the internal clock minus one, in system clocks |
| txIntEn | input | 1 | Enable for the empty interrupt request |
| endIntEn | input | 1 | Enable for the transmit-end interrupt request |
| rxErr | input | 3 | Pending receive error flags (overrun, framing, parity) |
| sckIn | input | 1 | External serial clock |
| txOut | output | 1 | Serial data |
| sckOut | output | 1 | Serial clock output (internal mode) |
| emptyFlag | output | 1 | Holding register empty |
| endFlag | output | 1 | Transmission ended |
| txIrq | output | 1 | Empty interrupt request |
| endIrq | output | 1 | Transmit-end interrupt request |

## Verification
The hardest case to reach from the ports is the hand-off at the end of the last bit. The frame chains or ends depending on whether a host write arrived during the frame. The bench watches emptyFlag and writes the next byte as soon as the shift register has taken the previous one. It does this in random bursts with random divider values, so the edge that closes the last bit always finds a pending byte, and it measures every rising-edge interval of the serial clock for a gap. The receive-error gate and the external-clock path are driven directly, with edges supplied while the transmitter is idle and while a byte waits.

// File: rtl/syncTxPkg.sv
package syncTxPkg;
  typedef enum logic {ST_IDLE, ST_RUN} txState_t;

  typedef struct packed {
    logic load;
    logic shift;
  } txStrobe_t;
endpackage

// File: rtl/syncTxEdge.sv
module syncTxEdge (
  input  logic clk,
  input  logic rstN,
  input  logic sckIn,
  output logic fallPulse
);
  logic [2:0] syncSh;

  always_ff @(posedge clk) begin
    if (!rstN) syncSh <= 3'b111;
    else       syncSh <= {syncSh[1:0], sckIn};
  end

  assign fallPulse = syncSh[2] & ~syncSh[1];
endmodule

// File: rtl/syncTxData.sv
module syncTxData
  import syncTxPkg::*;
#(
  parameter int FRAME_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [FRAME_W-1:0] wrData,
  input  txStrobe_t          strobe,
  output logic               txOut
);
  logic [FRAME_W-1:0] dataReg;
  logic [FRAME_W-2:0] restReg;
  logic               txBit;

  always_ff @(posedge clk) begin
    if (!rstN) dataReg <= '0;
    else if (wrEn) dataReg <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      restReg <= '0;
      txBit   <= 1'b1;
    end else if (strobe.load) begin
      restReg <= dataReg[FRAME_W-1:1];
      txBit   <= dataReg[0];
    end else if (strobe.shift) begin
      txBit   <= restReg[0];
      restReg <= {1'b0, restReg[FRAME_W-2:1]};
    end
  end

  assign txOut = txBit;
endmodule

// File: rtl/syncTxCtrl.sv
module syncTxCtrl
  import syncTxPkg::*;
#(
  parameter int FRAME_W = 8,
  parameter int DIV_W   = 8,
  parameter int ERR_W   = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             extClkMode,
  input  logic [DIV_W-1:0] clkDiv,
  input  logic [ERR_W-1:0] rxErr,
  input  logic             extFall,
  output txStrobe_t        strobe,
  output logic             emptyFlag,
  output logic             endFlag,
  output logic             sckReg
);
  localparam int CNT_W = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);

  txState_t         state;
  logic [CNT_W-1:0] bitCnt;
  logic [DIV_W-1:0] divCnt;
  logic             running, startOk, tick, fallEv, lastBit, endFrame, finish;

  assign running  = (state == ST_RUN);
  assign startOk  = !emptyFlag && (rxErr == '0);
  assign tick     = (divCnt == clkDiv);
  assign fallEv   = extClkMode ? extFall : (tick && sckReg);
  assign lastBit  = (bitCnt == LAST_BIT);
  assign endFrame = running && fallEv && lastBit;
  assign finish   = endFrame && !startOk;

  always_comb begin
    strobe.load  = (!running && startOk && (extClkMode ? extFall : 1'b1))
                 || (endFrame && startOk);
    strobe.shift = running && fallEv && !lastBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
    end else if (strobe.load) begin
      state  <= ST_RUN;
      bitCnt <= '0;
    end else if (strobe.shift) begin
      bitCnt <= bitCnt + 1'b1;
    end else if (finish) begin
      state  <= ST_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt <= '0;
      sckReg <= 1'b1;
    end else if (extClkMode) begin
      divCnt <= '0;
      sckReg <= 1'b1;
    end else if (strobe.load) begin
      divCnt <= '0;
      sckReg <= 1'b0;
    end else if (running) begin
      if (tick) begin
        divCnt <= '0;
        sckReg <= finish ? 1'b1 : ~sckReg;
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      emptyFlag <= 1'b1;
      endFlag   <= 1'b1;
    end else begin
      if (wrEn)             emptyFlag <= 1'b0;
      else if (strobe.load) emptyFlag <= 1'b1;
      if (wrEn)             endFlag   <= 1'b0;
      else if (finish)      endFlag   <= 1'b1;
    end
  end
endmodule

// File: rtl/syncSerialTx.sv
module syncSerialTx
  import syncTxPkg::*;
#(
  parameter int FRAME_W = 8,
  parameter int DIV_W   = 8,
  parameter int ERR_W   = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [FRAME_W-1:0] wrData,
  input  logic               extClkMode,
  input  logic [DIV_W-1:0]   clkDiv,
  input  logic               txIntEn,
  input  logic               endIntEn,
  input  logic [ERR_W-1:0]   rxErr,
  input  logic               sckIn,
  output logic               txOut,
  output logic               sckOut,
  output logic               emptyFlag,
  output logic               endFlag,
  output logic               txIrq,
  output logic               endIrq
);
  txStrobe_t strobe;
  logic      extFall;

  syncTxEdge u_edge (
    .clk       (clk),
    .rstN      (rstN),
    .sckIn     (sckIn),
    .fallPulse (extFall)
  );

  syncTxCtrl #(.FRAME_W(FRAME_W), .DIV_W(DIV_W), .ERR_W(ERR_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .extClkMode (extClkMode),
    .clkDiv     (clkDiv),
    .rxErr      (rxErr),
    .extFall    (extFall),
    .strobe     (strobe),
    .emptyFlag  (emptyFlag),
    .endFlag    (endFlag),
    .sckReg     (sckOut)
  );

  syncTxData #(.FRAME_W(FRAME_W)) u_data (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrData (wrData),
    .strobe (strobe),
    .txOut  (txOut)
  );

  assign txIrq  = txIntEn  & emptyFlag;
  assign endIrq = endIntEn & endFlag;
endmodule

// File: rtl/syncTxChk.sv
module syncTxChk #(
  parameter int ERR_W = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic             extClkMode,
  input logic [ERR_W-1:0] rxErr,
  input logic             emptyFlag,
  input logic             endFlag,
  input logic             txOut,
  input logic             sckOut
);
  AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (!emptyFlag && !endFlag)); // R2

  AST_RXERR_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (rxErr != '0) |=> !$rose(emptyFlag)); // R11

  AST_SCK_REST_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (!extClkMode && endFlag) |-> sckOut); // R9

  AST_EXT_SCK_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    extClkMode |-> sckOut); // R10

  AST_IDLE_LINE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (endFlag && $past(endFlag)) |-> $stable(txOut)); // R8

  AST_DATA_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
    (!extClkMode && $past(!extClkMode) && !$stable(txOut)) |-> $fell(sckOut)); // R3
endmodule

bind syncSerialTx syncTxChk #(.ERR_W(ERR_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .wrEn       (wrEn),
  .extClkMode (extClkMode),
  .rxErr      (rxErr),
  .emptyFlag  (emptyFlag),
  .endFlag    (endFlag),
  .txOut      (txOut),
  .sckOut     (sckOut)
);

// File: tb/syncSerialTx_tb.sv
module syncSerialTx_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic       extClkMode = 1'b0;
  logic [7:0] clkDiv = 8'd1;
  logic       txIntEn = 1'b0;
  logic       endIntEn = 1'b0;
  logic [2:0] rxErr = '0;
  logic       sckIn = 1'b1;
  logic       txOut, sckOut, emptyFlag, endFlag, txIrq, endIrq;

  syncSerialTx u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .extClkMode(extClkMode), .clkDiv(clkDiv), .txIntEn(txIntEn),
    .endIntEn(endIntEn), .rxErr(rxErr), .sckIn(sckIn),
    .txOut(txOut), .sckOut(sckOut), .emptyFlag(emptyFlag),
    .endFlag(endFlag), .txIrq(txIrq), .endIrq(endIrq)
  );

  always #10 clk = ~clk;

  int cycle = 0;
  always @(posedge clk) cycle++;

  int checks = 0, bad = 0;
  bit done = 0;
  logic [7:0] sentQ[$];
  logic [7:0] recvQ[$];
  logic [7:0] curByte = '0;
  int bitIdx = 0;
  int periodExp = 4;
  int lastRise = -1;
  int oddCnt = 0;
  logic prevSck = 1'b1;

  function automatic int periodOf(int d);
    return 2 * (d + 1);
  endfunction

  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic takeBit(logic b);
    curByte[bitIdx] = b;
    bitIdx++;
    if (bitIdx == 8) begin
      recvQ.push_back(curByte);
      bitIdx = 0;
    end
  endtask

  // receiver model for the internal clock: sample data at each rising edge
  always @(negedge clk) begin
    if (rstN && !extClkMode && !prevSck && sckOut) begin
      takeBit(txOut);
      if (lastRise >= 0 && (cycle - lastRise) != periodExp) oddCnt++;
      lastRise = cycle;
    end
    prevSck = sckOut;
  end

  task automatic hostWrite(logic [7:0] v);
    wrData = v;
    wrEn   = 1'b1;
    @(negedge clk);
    wrEn   = 1'b0;
    sentQ.push_back(v);
  endtask

  task automatic waitEnd();
    do @(negedge clk); while (!endFlag);
  endtask

  task automatic compareQueues(string req);
    check(req, recvQ.size(), sentQ.size(), "frame count");
    for (int i = 0; i < sentQ.size() && i < recvQ.size(); i++)
      check(req, recvQ[i], sentQ[i], "frame data");
    recvQ.delete();
    sentQ.delete();
  endtask

  initial begin
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", emptyFlag, 1, "emptyFlag after reset");
    check("R1", endFlag, 1, "endFlag after reset");
    check("R1", txOut, 1, "txOut after reset");
    check("R1", sckOut, 1, "sckOut after reset");

    // directed single frame, internal clock
    clkDiv = 8'd1; periodExp = periodOf(1); lastRise = -1; oddCnt = 0;
    txIntEn = 1'b1; endIntEn = 1'b1;
    hostWrite(8'h35);
    check("R2", emptyFlag, 0, "emptyFlag after write");
    check("R2", endFlag, 0, "endFlag after write");
    check("R6", endIrq, 0, "endIrq with endFlag low");
    check("R5", txIrq, 0, "txIrq with emptyFlag low");
    @(negedge clk);
    check("R4", emptyFlag, 1, "emptyFlag after load");
    check("R5", txIrq, 1, "txIrq after load");
    check("R4", txOut, 1, "bit 0 on line");
    check("R4", sckOut, 0, "sckOut low at load");
    waitEnd();
    check("R8", txOut, 0, "line holds last bit");
    check("R9", sckOut, 1, "sckOut rests high");
    check("R6", endIrq, 1, "endIrq at end");
    compareQueues("R3");
    check("R9", oddCnt, 0, "clock period intervals");

    // random chained bursts
    for (int burst = 0; burst < 6; burst++) begin
      int div, n;
      div = int'($urandom_range(0, 3));
      clkDiv = 8'(div);
      periodExp = periodOf(div); lastRise = -1; oddCnt = 0;
      txIntEn = 1'($urandom_range(0, 1));
      n = int'($urandom_range(2, 5));
      for (int k = 0; k < n; k++) begin
        if (k > 0) begin
          do @(negedge clk); while (!emptyFlag);
          check("R7", endFlag, 0, "no end mid-burst");
          check("R5", txIrq, int'(txIntEn), "txIrq follows enable");
        end
        hostWrite(8'($urandom));
      end
      waitEnd();
      compareQueues("R7");
      check("R7", oddCnt, 0, "gap-free clock across frames");
    end

    // receive-error gating
    clkDiv = 8'd0; periodExp = periodOf(0); lastRise = -1; oddCnt = 0;
    rxErr = 3'b100;
    hostWrite(8'hC3);
    repeat (20) @(negedge clk);
    check("R11", emptyFlag, 0, "byte held while error pending");
    check("R11", sckOut, 1, "no clock while error pending");
    check("R11", recvQ.size(), 0, "no frame while error pending");
    rxErr = 3'b000;
    waitEnd();
    compareQueues("R11");

    // external clock mode
    extClkMode = 1'b1;
    repeat (2) @(negedge clk);
    for (int p = 0; p < 2; p++) begin
      sckIn = 1'b0; repeat (6) @(negedge clk);
      sckIn = 1'b1; repeat (6) @(negedge clk);
    end
    check("R10", txOut, 1, "idle edges leave line");
    check("R10", endFlag, 1, "idle edges leave endFlag");
    hostWrite(8'h69);
    repeat (4) @(negedge clk);
    check("R10", emptyFlag, 0, "waits for external fall");
    for (int i = 0; i < 9; i++) begin
      sckIn = 1'b0;
      repeat (8) @(negedge clk);
      if (i == 0) check("R10", emptyFlag, 1, "loaded on external fall");
      check("R10", sckOut, 1, "sckOut held high");
      sckIn = 1'b1;
      if (i < 8) takeBit(txOut);
      repeat (8) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    check("R10", endFlag, 1, "end after last external fall");
    check("R8", txOut, 0, "line holds last bit, external");
    compareQueues("R10");

    done = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    wait (cycle >= 150000);
    if (!done) begin
      checks++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cycle);
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule